// File: doc/BRIEF.md
# Smart-Card Character Error Handler

This block sits beside the character engine of an asynchronous smart-card UART. It deals with errors one character at a time and supports both the character protocol (T=0) and the block protocol (T=1). On the receive side it counts characters that fail the parity check. When a programmable limit is reached it raises a sticky error flag, and only a read of the status register clears that flag.

On the transmit side in T=0, the card can refuse a character by signalling NAK. The block then does one of two things:
- It schedules an automatic resend of the same character a bounded number of times. The resend is timed from the start of the refused character.
- If automatic retries are disabled, it reports the earlier start time that applies when software rewrites the character itself.

All timing uses a half-ETU tick. Both resend instants are therefore whole counts: 30 half-ETUs for an automatic resend and 27 for a manual one. A single 3-bit field sets two things: the parity error limit, and the number of automatic retries.

Top module: `sc_char_err`

## Requirements
- R1: After a synchronous reset the error flag is 0, the resend request is 0 and the resend start time is 0.
- R2: In T=0 (proto_t1_i = 0) the error flag rises on the (limit_i + 1)-th bad-parity character counted since the last clear and stays 0 before that; a limit of 0 sets it on the first bad character.
- R3: In T=0 a character received with good parity resets the bad-character count to zero.
- R4: Once set, the error flag holds until stat_read_i is pulsed. A read clears it on the next edge, except that a set condition in the same cycle wins.
- R5: In T=1 (proto_t1_i = 1) the count is not used: the first bad-parity character sets the flag whatever limit_i is, and good characters have no effect.
- R6: In T=0 with retries left, a NAK leads to a one-cycle resend_req_o pulse. The pulse appears in the cycle after the 30th half-ETU tick counted from the start of the refused character, and resend_at_o then reads 30.
- R7: A character gets at most limit_i automatic resends. The retry budget reloads at each new character start (tx_start_i), and each automatic resend restarts the half-ETU count.
- R8: With a captured limit of 0, a NAK triggers no automatic resend and does not set the flag, and resend_at_o reads 27.
- R9: A NAK after the retry budget is spent triggers no resend and sets the error flag.
- R10: In T=1, a NAK on a transmitted character is ignored: there is no resend, resend_at_o keeps its value and the flag is unchanged.
- R11: The protocol select and the limit used by the transmit side are captured at tx_start_i, and later changes during that character have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_t1_i | input | 1 | 0 = T=0 character protocol, 1 = T=1 block protocol |
| limit_i | input | 3 | Parity error limit minus one, and the automatic retry count |
| half_etu_tick_i | input | 1 | One-cycle pulse every half ETU |
| rx_valid_i | input | 1 | One-cycle pulse: a received character is complete |
| rx_parity_bad_i | input | 1 | Parity of the received character failed (qualified by rx_valid_i) |
| tx_start_i | input | 1 | One-cycle pulse: a new character from the transmit path starts |
| tx_done_i | input | 1 | One-cycle pulse: the transmitted character has finished, with its error-signal window |
| tx_nak_i | input | 1 | The card signalled NAK for the character (qualified by tx_done_i) |
| stat_read_i | input | 1 | One-cycle pulse: the status register was read |
| err_flag_o | output | 1 | Sticky parity/retry error flag |
| resend_req_o | output | 1 | One-cycle pulse: start the automatic resend now |
| resend_at_o | output | 6 | Resend start time in half-ETUs from the start of the refused character |

## Verification
Each result has a fixed latency after its stimulus:
- A receive event is registered, so its effect on the flag is visible one edge after rx_valid_i.
- A spent retry budget sets the flag two edges after tx_done_i, because it passes through a registered give-up pulse.
- resend_at_o follows one edge after tx_done_i.
- resend_req_o rises one edge after the 30th tick.

The bench samples direct checks one nanosecond after the edge that carries the effect, and pads with idle cycles where the path is two registers deep. Every flag rise and every resend pulse goes through a queue of expected events. For each resend the monitor also checks that exactly 30 ticks were driven since the character started. Any event nobody expected is a failure, as is an expected event that never arrives.

// File: rtl/sc_err_pkg.sv
package sc_err_pkg;
  typedef enum logic {
    PROTO_CHAR  = 1'b0,
    PROTO_BLOCK = 1'b1
  } proto_e;

  localparam int unsigned LIMIT_W        = 3;
  localparam int unsigned TIME_W         = 6;
  localparam int unsigned HALF_ETU_AUTO  = 30;
  localparam int unsigned HALF_ETU_MANUAL = 27;
endpackage

// File: rtl/sc_rx_parity_tally.sv
module sc_rx_parity_tally
  import sc_err_pkg::*;
#(
  parameter int unsigned CNT_W = LIMIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  proto_e           proto,
  input  logic [CNT_W-1:0] limit,
  input  logic             rx_valid,
  input  logic             rx_bad,
  input  logic             ext_set,
  input  logic             stat_read,
  output logic             flag
);
  logic [CNT_W-1:0] tally;
  logic             hit;
  logic             set_evt;

  always_comb begin
    hit     = rx_valid && rx_bad && ((proto == PROTO_BLOCK) || (tally >= limit));
    set_evt = hit || ext_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tally <= '0;
      flag  <= 1'b0;
    end else begin
      if (rx_valid && proto == PROTO_CHAR) begin
        if (!rx_bad || tally >= limit) tally <= '0;
        else                           tally <= tally + 1'b1;
      end
      if (set_evt)        flag <= 1'b1;
      else if (stat_read) flag <= 1'b0;
    end
  end

  // R3: a good character in T=0 leaves the count at zero
  p_good_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_bad && proto == PROTO_CHAR) |=> (tally == '0));

  // R4: flag holds without a read
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_read) |=> flag);

  // R4: a read with no concurrent set clears the flag
  p_read_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_read && !rx_valid && !ext_set) |=> !flag);

  // R5: in T=1 the first bad character sets the flag
  p_block_first_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_bad && proto == PROTO_BLOCK) |=> flag);
endmodule

// File: rtl/sc_tx_retry_ctl.sv
module sc_tx_retry_ctl
  import sc_err_pkg::*;
#(
  parameter int unsigned CNT_W      = LIMIT_W,
  parameter int unsigned TW         = TIME_W,
  parameter int unsigned AUTO_HALF  = HALF_ETU_AUTO,
  parameter int unsigned MAN_HALF   = HALF_ETU_MANUAL
) (
  input  logic             clk,
  input  logic             rst,
  input  proto_e           proto,
  input  logic [CNT_W-1:0] limit,
  input  logic             tick,
  input  logic             tx_start,
  input  logic             tx_done,
  input  logic             tx_nak,
  output logic             resend_req,
  output logic [TW-1:0]    resend_at,
  output logic             give_up
);
  localparam logic [TW-1:0] FIRE_AT = TW'(AUTO_HALF - 1);
  localparam logic [TW-1:0] AT_AUTO = TW'(AUTO_HALF);
  localparam logic [TW-1:0] AT_MAN  = TW'(MAN_HALF);
  localparam logic [TW-1:0] T_MAX   = '1;

  proto_e           proto_cap;
  logic [CNT_W-1:0] lim_cap;
  logic [CNT_W-1:0] left;
  logic             pending;
  logic [TW-1:0]    timer;
  logic             nak_evt;
  logic             fire;

  always_comb begin
    nak_evt = tx_done && tx_nak && (proto_cap == PROTO_CHAR) && !tx_start;
    fire    = pending && tick && (timer >= FIRE_AT) && !tx_start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      proto_cap  <= PROTO_CHAR;
      lim_cap    <= '0;
      left       <= '0;
      pending    <= 1'b0;
      timer      <= '0;
      resend_req <= 1'b0;
      resend_at  <= '0;
      give_up    <= 1'b0;
    end else begin
      resend_req <= fire;
      give_up    <= 1'b0;
      if (tx_start) begin
        proto_cap <= proto;
        lim_cap   <= limit;
        left      <= limit;
        timer     <= '0;
        pending   <= 1'b0;
      end else begin
        if (fire)                        timer <= '0;
        else if (tick && timer != T_MAX) timer <= timer + 1'b1;
        if (fire) pending <= 1'b0;
        if (nak_evt) begin
          if (lim_cap == '0) begin
            resend_at <= AT_MAN;
          end else if (left != '0) begin
            left      <= left - 1'b1;
            pending   <= 1'b1;
            resend_at <= AT_AUTO;
          end else begin
            give_up <= 1'b1;
          end
        end
      end
    end
  end

  // R6: the resend request is a single-cycle pulse
  p_req_single_r6: assert property (@(posedge clk) disable iff (rst)
    resend_req |=> !resend_req);

  // R7: the retry budget never exceeds the captured limit
  p_budget_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (left <= lim_cap));

  // R8: manual mode never arms an automatic resend
  p_manual_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (nak_evt && lim_cap == '0 && !pending) |=> !pending);

  // R10: a NAK in T=1 leaves the resend time alone
  p_block_nak_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_nak && proto_cap == PROTO_BLOCK && !tx_start) |=> $stable(resend_at));
endmodule

// File: rtl/sc_char_err.sv
module sc_char_err
  import sc_err_pkg::*;
#(
  parameter int unsigned CNT_W = LIMIT_W,
  parameter int unsigned TW    = TIME_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             proto_t1_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             half_etu_tick_i,
  input  logic             rx_valid_i,
  input  logic             rx_parity_bad_i,
  input  logic             tx_start_i,
  input  logic             tx_done_i,
  input  logic             tx_nak_i,
  input  logic             stat_read_i,
  output logic             err_flag_o,
  output logic             resend_req_o,
  output logic [TW-1:0]    resend_at_o
);
  proto_e proto;
  logic   give_up;

  assign proto = proto_t1_i ? PROTO_BLOCK : PROTO_CHAR;

  sc_rx_parity_tally #(.CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .proto     (proto),
    .limit     (limit_i),
    .rx_valid  (rx_valid_i),
    .rx_bad    (rx_parity_bad_i),
    .ext_set   (give_up),
    .stat_read (stat_read_i),
    .flag      (err_flag_o)
  );

  sc_tx_retry_ctl #(.CNT_W(CNT_W), .TW(TW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .proto      (proto),
    .limit      (limit_i),
    .tick       (half_etu_tick_i),
    .tx_start   (tx_start_i),
    .tx_done    (tx_done_i),
    .tx_nak     (tx_nak_i),
    .resend_req (resend_req_o),
    .resend_at  (resend_at_o),
    .give_up    (give_up)
  );

  // R9: a spent retry budget raises the flag on the next edge
  p_giveup_flag_r9: assert property (@(posedge clk) disable iff (rst)
    give_up |=> err_flag_o);
endmodule

// File: tb/sc_char_err_test.sv
module sc_char_err_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       proto_t1_i, half_etu_tick_i, rx_valid_i, rx_parity_bad_i;
  logic       tx_start_i, tx_done_i, tx_nak_i, stat_read_i;
  logic [2:0] limit_i;
  logic       err_flag_o, resend_req_o;
  logic [5:0] resend_at_o;

  always #4 clk = ~clk;

  sc_char_err uut (
    .clk(clk), .rst(rst), .proto_t1_i(proto_t1_i), .limit_i(limit_i),
    .half_etu_tick_i(half_etu_tick_i), .rx_valid_i(rx_valid_i),
    .rx_parity_bad_i(rx_parity_bad_i), .tx_start_i(tx_start_i),
    .tx_done_i(tx_done_i), .tx_nak_i(tx_nak_i), .stat_read_i(stat_read_i),
    .err_flag_o(err_flag_o), .resend_req_o(resend_req_o), .resend_at_o(resend_at_o)
  );

  localparam int EV_RESEND = 1;
  localparam int EV_FLAG   = 2;
  typedef struct { int kind; string req; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0, ticks_since = 0;
  bit flag_prev = 1'b0;
  bit finished = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(int k, string r);
    exp_t e;
    e.kind = k; e.req = r;
    q.push_back(e);
  endtask

  // monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (resend_req_o) begin
        if (q.size() == 0) check(1'b0, "R6 unexpected resend", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(e.kind == EV_RESEND, e.req, EV_RESEND, e.kind);
          check(ticks_since == 30, e.req, ticks_since, 30);
          check(resend_at_o == 6'd30, e.req, int'(resend_at_o), 30);
        end
        ticks_since = 0;
      end
      if (err_flag_o && !flag_prev) begin
        if (q.size() == 0) check(1'b0, "R4 unexpected flag rise", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(e.kind == EV_FLAG, e.req, EV_FLAG, e.kind);
        end
      end
      flag_prev = err_flag_o;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rx_char(bit bad);
    rx_valid_i = 1'b1; rx_parity_bad_i = bad;
    step(1);
    rx_valid_i = 1'b0; rx_parity_bad_i = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      half_etu_tick_i = 1'b1; ticks_since++;
      step(1);
      half_etu_tick_i = 1'b0;
      step(1);
    end
  endtask

  task automatic tx_begin();
    tx_start_i = 1'b1; ticks_since = 0;
    step(1);
    tx_start_i = 1'b0;
  endtask

  task automatic tx_end(bit nak);
    tx_done_i = 1'b1; tx_nak_i = nak;
    step(1);
    tx_done_i = 1'b0; tx_nak_i = 1'b0;
  endtask

  task automatic read_stat();
    stat_read_i = 1'b1;
    step(1);
    stat_read_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    rst = 1'b1; proto_t1_i = 1'b0; limit_i = 3'd0; half_etu_tick_i = 1'b0;
    rx_valid_i = 1'b0; rx_parity_bad_i = 1'b0; tx_start_i = 1'b0;
    tx_done_i = 1'b0; tx_nak_i = 1'b0; stat_read_i = 1'b0;
    step(3);
    // R1 reset state
    check(err_flag_o == 1'b0, "R1 flag", int'(err_flag_o), 0);
    check(resend_req_o == 1'b0, "R1 req", int'(resend_req_o), 0);
    check(resend_at_o == 6'd0, "R1 at", int'(resend_at_o), 0);
    rst = 1'b0;
    step(2);

    // R2: limit 2 -> third bad character sets the flag
    limit_i = 3'd2;
    rx_char(1); rx_char(1);
    check(err_flag_o == 1'b0, "R2 early", int'(err_flag_o), 0);
    expect_ev(EV_FLAG, "R2 flag");
    rx_char(1);
    check(err_flag_o == 1'b1, "R2 third", int'(err_flag_o), 1);
    read_stat();
    check(err_flag_o == 1'b0, "R4 cleared", int'(err_flag_o), 0);

    // R3: good character resets the count
    rx_char(1); rx_char(1); rx_char(0); rx_char(1); rx_char(1);
    check(err_flag_o == 1'b0, "R3 reset count", int'(err_flag_o), 0);
    expect_ev(EV_FLAG, "R3 flag");
    rx_char(1);
    check(err_flag_o == 1'b1, "R3 after", int'(err_flag_o), 1);

    // R4: sticky through good characters and idle
    rx_char(0); rx_char(0); step(5);
    check(err_flag_o == 1'b1, "R4 sticky", int'(err_flag_o), 1);
    read_stat();
    check(err_flag_o == 1'b0, "R4 read", int'(err_flag_o), 0);

    // R4: set wins over a same-cycle read (limit 0 -> first bad sets)
    limit_i = 3'd0;
    expect_ev(EV_FLAG, "R4 set wins");
    stat_read_i = 1'b1;
    rx_char(1);
    stat_read_i = 1'b0;
    check(err_flag_o == 1'b1, "R4 set wins", int'(err_flag_o), 1);
    read_stat();

    // R5: T=1 ignores limit, first bad sets
    proto_t1_i = 1'b1; limit_i = 3'd7;
    rx_char(0); rx_char(0);
    check(err_flag_o == 1'b0, "R5 good", int'(err_flag_o), 0);
    expect_ev(EV_FLAG, "R5 first bad");
    rx_char(1);
    check(err_flag_o == 1'b1, "R5 first bad", int'(err_flag_o), 1);
    read_stat();

    // R6 R7 R9: two automatic resends then give up
    proto_t1_i = 1'b0; limit_i = 3'd2;
    tx_begin();
    ticks(20);
    tx_end(1);
    check(resend_at_o == 6'd30, "R6 at", int'(resend_at_o), 30);
    expect_ev(EV_RESEND, "R6 first resend");
    ticks(10);
    ticks(22);
    tx_end(1);
    expect_ev(EV_RESEND, "R7 second resend");
    ticks(8);
    ticks(22);
    expect_ev(EV_FLAG, "R9 exhausted");
    tx_end(1);
    step(3);
    check(err_flag_o == 1'b1, "R9 flag", int'(err_flag_o), 1);
    ticks(10);
    read_stat();

    // R7 reload and R11 capture: limit 1 captured, then raised mid-character
    limit_i = 3'd1;
    tx_begin();
    limit_i = 3'd5;
    ticks(20);
    tx_end(1);
    expect_ev(EV_RESEND, "R11 captured resend");
    ticks(10);
    ticks(20);
    expect_ev(EV_FLAG, "R11 captured limit");
    tx_end(1);
    step(3);
    check(err_flag_o == 1'b1, "R11 flag", int'(err_flag_o), 1);
    ticks(12);
    read_stat();
    check(err_flag_o == 1'b0, "R4 read after R11", int'(err_flag_o), 0);

    // R8: limit 0 -> manual, start time 27
    limit_i = 3'd0;
    tx_begin();
    ticks(20);
    tx_end(1);
    check(resend_at_o == 6'd27, "R8 at", int'(resend_at_o), 27);
    ticks(12); step(3);
    check(err_flag_o == 1'b0, "R8 flag", int'(err_flag_o), 0);

    // R10: T=1 NAK ignored
    proto_t1_i = 1'b1; limit_i = 3'd3;
    tx_begin();
    ticks(20);
    tx_end(1);
    step(2);
    check(resend_at_o == 6'd27, "R10 at", int'(resend_at_o), 27);
    ticks(12);
    check(err_flag_o == 1'b0, "R10 flag", int'(err_flag_o), 0);

    step(4);
    check(q.size() == 0, "R6 R9 missing events", q.size(), 0);
    finished = 1'b1;
    summary();
  end
endmodule